// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the three active-low control strobes of an SDRAM command bus, samples them on each rising clock edge, and turns each sample into a single decoded command: open a row, read, write, close (precharge) or refresh. Each decoded command appears as a one-cycle pulse on its own output. For every bank it keeps an open/closed flag and a countdown of the cycles left before a column access to that bank becomes legal.

Commands that break the bank rules are refused rather than passed on. Refused commands include a column access to a closed bank or one issued before the activate-to-column delay has run out, a second activate to a bank that is already open, and a refresh while any bank is open. A refused command raises a one-cycle error pulse, produces no command pulse and changes no state. The block owns the refresh address. A counter, cleared by reset, names the row and bank that the next refresh will hit, and it steps once for each accepted refresh. A memory-controller checker or a memory model front end can use the block to follow bank state without decoding the bus itself.

Top module: `sdcmd_tracker`

## Requirements
- R1: Strobes {ras_n,cas_n,we_n} are sampled on each rising edge. 011 is activate, 101 is read, 100 is write, 010 is precharge and 001 is refresh. 111, 110 and 000 give no pulse and no error. A command's pulse is high for exactly the one cycle after its sampling edge.
- R2: An activate to a closed bank sets bank_open[bank_sel] after the sampling edge and pulses act_p. An activate to an open bank pulses err_p instead and leaves state unchanged.
- R3: A read or write to bank b is accepted only if it is sampled at least T_ACT2COL edges after the edge that sampled b's activate. An earlier one pulses err_p and gives no rd_p or wr_p.
- R4: A read or write to a closed bank pulses err_p and gives no rd_p or wr_p.
- R5: Banks are tracked independently. Several may be open at once, and an activate of one bank does not delay column access to another bank that is already ready.
- R6: Precharge closes bank bank_sel, or every bank when pre_all is 1. It is always accepted, even for a bank that is already closed, and it pulses pre_p.
- R7: Refresh with any bank open pulses err_p and leaves the refresh address unchanged. With all banks closed it pulses ref_p and advances the address.
- R8: With n accepted refreshes since reset, ref_bank = n mod NUM_BANKS and ref_row = (n / NUM_BANKS) mod 2^ROW_W. The bank field moves fastest and the address wraps to zero.
- R9: While rst_n is low, all pulses are 0, all banks are closed and the refresh address is 0.
- R10: At most one of act_p, rd_p, wr_p, pre_p, ref_p and err_p is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobes sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write-enable strobe, active low |
| bank_sel | input | BANK_W | Bank addressed by the command |
| pre_all | input | 1 | Address line that widens a precharge to all banks |
| act_p | output | 1 | Accepted activate pulse |
| rd_p | output | 1 | Accepted read pulse |
| wr_p | output | 1 | Accepted write pulse |
| pre_p | output | 1 | Precharge pulse |
| ref_p | output | 1 | Accepted refresh pulse |
| err_p | output | 1 | Refused (illegal) command pulse |
| bank_open | output | NUM_BANKS | Per-bank open flags |
| ref_row | output | ROW_W | Row the next refresh targets |
| ref_bank | output | BANK_W | Bank the next refresh targets |

## Verification
All outputs of this block (the command and error pulses, the bank_open flags and the refresh address) are due in the cycle that follows the rising edge that sampled the command. None of them is due later. The bench drives each command on a falling edge, waits for the next rising edge, and compares all outputs 1 ns after it. The bench counts sampling edges to decide whether a column access falls before or after T_ACT2COL. It sweeps the delays 1 through T_ACT2COL+1 on every bank, so both sides of the boundary are compared in the exact cycle they resolve.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

   typedef enum logic [2:0] {
      CMD_IDLE,
      CMD_OPEN,
      CMD_READ,
      CMD_WRITE,
      CMD_CLOSE,
      CMD_REFRESH
   } cmd_e;

   // Strobes are active low: {ras_n, cas_n, we_n}
   function automatic cmd_e decode_strobes(input logic r_n, input logic c_n, input logic w_n);
      case ({r_n, c_n, w_n})
         3'b011:  return CMD_OPEN;
         3'b101:  return CMD_READ;
         3'b100:  return CMD_WRITE;
         3'b010:  return CMD_CLOSE;
         3'b001:  return CMD_REFRESH;
         default: return CMD_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
   import sdcmd_pkg::*;
(
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);

   always_comb begin
      cmd = decode_strobes(ras_n, cas_n, we_n);
   end

endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank #(
   parameter int T_ACT2COL = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic open_i,
   input  logic close_i,
   output logic is_open_o,
   output logic ready_o
);

   logic open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       open_q <= 1'b0;
      else if (open_i)  open_q <= 1'b1;
      else if (close_i) open_q <= 1'b0;
   end

   assign is_open_o = open_q;

   generate
      if (T_ACT2COL > 1) begin : g_timer
         localparam int TW = $clog2(T_ACT2COL);
         logic [TW-1:0] wait_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             wait_q <= '0;
            else if (open_i)        wait_q <= TW'(T_ACT2COL - 1);
            else if (close_i)       wait_q <= '0;
            else if (wait_q != '0)  wait_q <= wait_q - TW'(1);
         end

         assign ready_o = open_q && (wait_q == '0);

         // R3: a freshly opened bank is not ready on the next cycle
         assert_wait_after_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
            open_i |=> !ready_o);
      end else begin : g_no_timer
         assign ready_o = open_q;
      end
   endgenerate

   // R2: activate leaves the bank open
   assert_open_after_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
      open_i |=> is_open_o);

   // R6: precharge leaves the bank closed
   assert_closed_after_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (close_i && !open_i) |=> !is_open_o);

endmodule

// File: rtl/sdcmd_refcnt.sv
module sdcmd_refcnt #(
   parameter int BANK_W     = 2,
   parameter int ROW_W      = 12,
   parameter bit BANK_FAST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   output logic [ROW_W-1:0]  row_o,
   output logic [BANK_W-1:0] bank_o
);

   localparam int CNT_W = ROW_W + BANK_W;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (step_i) cnt_q <= cnt_q + CNT_W'(1);
   end

   generate
      if (BANK_FAST) begin : g_bank_low
         assign bank_o = cnt_q[BANK_W-1:0];
         assign row_o  = cnt_q[CNT_W-1:BANK_W];
      end else begin : g_row_low
         assign row_o  = cnt_q[ROW_W-1:0];
         assign bank_o = cnt_q[CNT_W-1:ROW_W];
      end
   endgenerate

   // R8: each accepted refresh advances the address by one
   assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |=> cnt_q == $past(cnt_q) + CNT_W'(1));

   // R7: without an accepted refresh the address holds
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(cnt_q));

endmodule

// File: rtl/sdcmd_tracker.sv
module sdcmd_tracker
   import sdcmd_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 12,
   parameter int T_ACT2COL = 3,
   parameter bit BANK_FAST = 1'b1,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic [BANK_W-1:0]    bank_sel,
   input  logic                 pre_all,
   output logic                 act_p,
   output logic                 rd_p,
   output logic                 wr_p,
   output logic                 pre_p,
   output logic                 ref_p,
   output logic                 err_p,
   output logic [NUM_BANKS-1:0] bank_open,
   output logic [ROW_W-1:0]     ref_row,
   output logic [BANK_W-1:0]    ref_bank
);

   generate
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two, at least 2");
      end
      if (T_ACT2COL < 1) begin : g_bad_delay
         $error("T_ACT2COL must be at least 1");
      end
      if (ROW_W < 1) begin : g_bad_row
         $error("ROW_W must be at least 1");
      end
   endgenerate

   cmd_e                 cmd;
   logic [NUM_BANKS-1:0] ready;
   logic                 sel_open, sel_ready, any_open;
   logic                 act_ok, rd_ok, wr_ok, ref_ok, pre_cmd, bad;

   sdcmd_decode u_dec (
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   assign sel_open  = bank_open[bank_sel];
   assign sel_ready = ready[bank_sel];
   assign any_open  = |bank_open;

   always_comb begin
      act_ok  = (cmd == CMD_OPEN)    && !sel_open;
      rd_ok   = (cmd == CMD_READ)    && sel_ready;
      wr_ok   = (cmd == CMD_WRITE)   && sel_ready;
      ref_ok  = (cmd == CMD_REFRESH) && !any_open;
      pre_cmd = (cmd == CMD_CLOSE);
      bad     = ((cmd == CMD_OPEN)    && sel_open)
             || ((cmd == CMD_READ)    && !sel_ready)
             || ((cmd == CMD_WRITE)   && !sel_ready)
             || ((cmd == CMD_REFRESH) && any_open);
   end

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic hit;
         assign hit = (bank_sel == BANK_W'(b));

         sdcmd_bank #(.T_ACT2COL(T_ACT2COL)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .open_i    (act_ok && hit),
            .close_i   (pre_cmd && (pre_all || hit)),
            .is_open_o (bank_open[b]),
            .ready_o   (ready[b])
         );
      end
   endgenerate

   sdcmd_refcnt #(
      .BANK_W    (BANK_W),
      .ROW_W     (ROW_W),
      .BANK_FAST (BANK_FAST)
   ) u_ref (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (ref_ok),
      .row_o  (ref_row),
      .bank_o (ref_bank)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_p <= 1'b0;
         rd_p  <= 1'b0;
         wr_p  <= 1'b0;
         pre_p <= 1'b0;
         ref_p <= 1'b0;
         err_p <= 1'b0;
      end else begin
         act_p <= act_ok;
         rd_p  <= rd_ok;
         wr_p  <= wr_ok;
         pre_p <= pre_cmd;
         ref_p <= ref_ok;
         err_p <= bad;
      end
   end

   // R10: pulses are mutually exclusive
   assert_one_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({act_p, rd_p, wr_p, pre_p, ref_p, err_p}));

   // R4: accepted column commands only target a bank that was open
   assert_col_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_p || wr_p) |-> $past(bank_open[bank_sel]));

   // R2: accepted activate only targets a bank that was closed
   assert_act_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      act_p |-> !$past(bank_open[bank_sel]));

   // R7: accepted refresh only when all banks were closed
   assert_ref_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ref_p |-> ($past(bank_open) == '0));

   // R6: a precharge with pre_all leaves every bank closed
   assert_pre_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_p && $past(pre_all)) |-> (bank_open == '0));

endmodule

// File: tb/sim_sdcmd_tracker.sv
`timescale 1ns/1ps
module sim_sdcmd_tracker;

   localparam int NB   = 4;
   localparam int BW   = 2;
   localparam int RW   = 3;
   localparam int TD   = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [BW-1:0] bank_sel = '0;
   logic          pre_all = 1'b0;
   logic          act_p, rd_p, wr_p, pre_p, ref_p, err_p;
   logic [NB-1:0] bank_open;
   logic [RW-1:0] ref_row;
   logic [BW-1:0] ref_bank;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int edge_n = 0;
   bit open_m [NB];
   int act_e  [NB];
   int refs   = 0;

   always #10 clk = ~clk;

   sdcmd_tracker #(.NUM_BANKS(NB), .ROW_W(RW), .T_ACT2COL(TD), .BANK_FAST(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .bank_sel(bank_sel), .pre_all(pre_all),
      .act_p(act_p), .rd_p(rd_p), .wr_p(wr_p), .pre_p(pre_p), .ref_p(ref_p), .err_p(err_p),
      .bank_open(bank_open), .ref_row(ref_row), .ref_bank(ref_bank)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < NB; i++) begin
         open_m[i] = 1'b0;
         act_e[i]  = 0;
      end
      refs = 0;
   endtask

   function automatic int open_vec();
      int v = 0;
      for (int i = 0; i < NB; i++) if (open_m[i]) v |= (1 << i);
      return v;
   endfunction

   // Pulse vector order: {act, rd, wr, pre, ref, err}
   task automatic issue(input bit r, input bit c, input bit w, input int b, input bit pa,
                        input string tag);
      int e_act, e_rd, e_wr, e_pre, e_ref, e_err;
      bit col_ok;
      @(negedge clk);
      ras_n = r; cas_n = c; we_n = w; bank_sel = b[BW-1:0]; pre_all = pa;
      @(posedge clk);
      edge_n++;
      e_act = 0; e_rd = 0; e_wr = 0; e_pre = 0; e_ref = 0; e_err = 0;
      col_ok = open_m[b] && ((edge_n - act_e[b]) >= TD);
      case ({r, c, w})
         3'b011: if (open_m[b]) e_err = 1; else begin e_act = 1; open_m[b] = 1'b1; act_e[b] = edge_n; end
         3'b101: if (col_ok) e_rd = 1; else e_err = 1;
         3'b100: if (col_ok) e_wr = 1; else e_err = 1;
         3'b010: begin
            e_pre = 1;
            if (pa) for (int i = 0; i < NB; i++) open_m[i] = 1'b0;
            else open_m[b] = 1'b0;
         end
         3'b001: if (open_vec() != 0) e_err = 1; else begin e_ref = 1; refs++; end
         default: ;
      endcase
      #1;
      chk(tag, "pulses", {26'd0, act_p, rd_p, wr_p, pre_p, ref_p, err_p},
          (e_act << 5) | (e_rd << 4) | (e_wr << 3) | (e_pre << 2) | (e_ref << 1) | e_err);
      chk(tag, "bank_open", int'(bank_open), open_vec());
      chk(tag, "ref_addr", {ref_row, ref_bank}, (((refs / NB) % (1 << RW)) << BW) | (refs % NB));
      ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; pre_all = 1'b0;
   endtask

   task automatic nop(input string tag);
      issue(1, 1, 1, 0, 0, tag);
   endtask

   task automatic act(input int b, input string tag);
      issue(0, 1, 1, b, 0, tag);
   endtask

   task automatic pre(input int b, input bit pa, input string tag);
      issue(0, 1, 0, b, pa, tag);
   endtask

   task automatic check_reset(input string tag);
      chk(tag, "pulses", {26'd0, act_p, rd_p, wr_p, pre_p, ref_p, err_p}, 0);
      chk(tag, "bank_open", int'(bank_open), 0);
      chk(tag, "ref_addr", {ref_row, ref_bank}, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R9 watchdog: actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      model_clear();
      repeat (3) @(posedge clk);
      #1 check_reset("R9");
      @(negedge clk);
      rst_n = 1'b1;

      // R1: every strobe pattern with all banks closed
      for (int k = 7; k >= 0; k--) begin
         issue(k[2], k[1], k[0], 0, 0, "R1");
      end
      pre(0, 1, "R1");

      // R3: activate-to-column delay swept across the boundary on every bank
      for (int b = 0; b < NB; b++) begin
         for (int j = 1; j <= TD + 1; j++) begin
            act(b, "R3");
            for (int n = 0; n < j - 1; n++) nop("R3");
            if (j % 2 == 0) issue(1, 0, 1, b, 0, "R3");
            else            issue(1, 0, 0, b, 0, "R3");
            pre(b, 1, "R3");
         end
      end

      // R4: column access to a closed bank
      issue(1, 0, 1, 2, 0, "R4");
      issue(1, 0, 0, 3, 0, "R4");

      // R2: second activate to an open bank is refused
      act(2, "R2");
      act(2, "R2");
      pre(2, 0, "R2");

      // R5: two open banks, interleaved column access
      act(0, "R5");
      nop("R5");
      act(1, "R5");
      issue(1, 0, 1, 0, 0, "R5");
      issue(1, 0, 0, 1, 0, "R5");
      issue(1, 0, 0, 1, 0, "R5");
      issue(1, 0, 1, 0, 0, "R5");
      issue(1, 0, 0, 1, 0, "R5");

      // R6: single precharge, precharge of a closed bank, then all banks
      act(3, "R6");
      pre(1, 0, "R6");
      pre(1, 0, "R6");
      pre(2, 0, "R6");
      pre(0, 1, "R6");

      // R7 / R10: refresh with a bank open is refused alone
      issue(0, 0, 1, 0, 0, "R7");
      act(3, "R7");
      issue(0, 0, 1, 1, 0, "R10");
      pre(3, 0, "R7");

      // R8: refresh address sweep through the full wrap
      for (int n = 0; n < NB * (1 << RW) + 2; n++) begin
         issue(0, 0, 1, n % NB, 0, "R8");
      end

      // R9: reset in mid run clears banks and refresh address
      act(1, "R9");
      act(2, "R9");
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1 check_reset("R9");
      model_clear();
      @(negedge clk);
      rst_n = 1'b1;
      act(1, "R9");
      issue(1, 0, 1, 1, 0, "R9");
      pre(1, 1, "R9");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule